// File: doc/BRIEF.md
# Programmable Down-Counting Tick Timer

This block is a 32-bit decrementing timer behind a small word-addressed register bus. Software loads a start value into the count register, picks a prescale divisor, and then turns on the power and run bits in the control register. The counter then steps down by one every (divisor + 1) clock cycles. When the count steps from 1 to 0, the block sets a sticky expiry flag in the control register. In the cycle after that edge, it drives a one-cycle interrupt pulse.

When the reload option is off, the counter stops at zero and stays there. When the reload option is on, the next prescaled step after zero loads the value held in the period register, and counting continues. A reload period of P therefore gives one interrupt every P + 1 steps.

Reads are combinational from the address. Writes take effect on the rising clock edge while the write strobe is high. All state is cleared by a synchronous, active-high reset.

Top module: `core_tick_timer`

## Requirements
- R1: After reset, all four registers read 0 and `irq` is low. The registers are control at offset 0x0, period at 0x4, divisor at 0x8 and count at 0xC.
- R2: The count changes only while control bit 0 (power) and bit 1 (run) are both 1. With control at 0x1, or at 0x0, the count holds its value.
- R3: With divisor value S, the count steps down once every S + 1 clock cycles. The first step comes S + 1 edges after the control write that starts the timer.
- R4: With control bit 2 (reload) at 0, the edge that takes the count from 1 to 0 has these effects:
  - It sets control bit 3 (expired).
  - It makes `irq` high for exactly the following cycle.
  - The count then stays at 0, and control reads 0xB.
- R5: With reload at 1, the prescaled step after the count reaches 0 loads the period value, and counting goes on. Every 1-to-0 step pulses `irq`, and control reads 0xF afterwards.
- R6: Writing control with bit 3 at 1 clears the expired flag. Writing control with bit 3 at 0 and bit 0 at 0 also clears it. Writing control with bit 3 at 0 and bit 0 at 1 keeps it.
- R7: The period register reads back the last value written, whether the timer is running or stopped.
- R8: A write to the count register takes priority over any step or reload in the same cycle, and it restarts the prescale phase. The next step follows S + 1 edges later.
- R9: Reads of any other offset, including misaligned ones and 0x10, return 0. Writes to those offsets change no register.
- R10: Starting the timer with count 0 and reload off raises no interrupt, and the count stays at 0.
- R11: After the timer is turned off with control 0x0 and then turned on again, it resumes from the count it held. It interrupts when that count reaches 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| irq | output | 1 | One-cycle expiry pulse |

## Verification
The one-shot mode is swept over every divisor from 0 to 3 and every start count from 1 to 5, and the count and `irq` are checked at every cycle. This sweep separates an off-by-one in the prescaler from one in the zero detect, and it separates a pulse that is a cycle early, late or stretched from a correct one. The reload mode is swept over several period and divisor pairs. These pairs show whether reload happens on the step after zero or on the step that reaches zero.

Four directed cases follow:
- Sticky-flag write patterns.
- A count write during a run.
- A start at zero.
- A stop and resume.

Together they separate write priority, prescaler restart and the clearing rules for the flag. Writes to unmapped offsets are followed by read-back of all four registers.

// File: rtl/core_tick_timer.sv
module core_tick_timer #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_PER  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_DIV  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFF_CNT  = ADDR_W'(12);

  logic              pwr_q, run_q, rld_q, exp_q;
  logic [DATA_W-1:0] per_q, div_q, cnt_q, phase_q;

  wire wr_ctrl = bus_wr && bus_addr == OFF_CTRL;
  wire wr_per  = bus_wr && bus_addr == OFF_PER;
  wire wr_div  = bus_wr && bus_addr == OFF_DIV;
  wire wr_cnt  = bus_wr && bus_addr == OFF_CNT;

  wire active     = pwr_q && run_q;
  wire phase_done = phase_q >= div_q;
  wire step       = active && phase_done && (cnt_q != '0 || rld_q) && !wr_cnt;
  wire expire     = step && cnt_q == DATA_W'(1);

  always_ff @(posedge clk) begin
    if (rst || wr_cnt || !active || phase_done) phase_q <= '0;
    else phase_q <= phase_q + DATA_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (wr_cnt) cnt_q <= bus_wdata;
    else if (step) cnt_q <= (cnt_q == '0) ? per_q : cnt_q - DATA_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q <= '0;
      div_q <= '0;
    end else begin
      if (wr_per) per_q <= bus_wdata;
      if (wr_div) div_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_q <= 1'b0;
      run_q <= 1'b0;
      rld_q <= 1'b0;
    end else if (wr_ctrl) begin
      pwr_q <= bus_wdata[0];
      run_q <= bus_wdata[1];
      rld_q <= bus_wdata[2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) exp_q <= 1'b0;
    else if (expire) exp_q <= 1'b1;
    else if (wr_ctrl && (bus_wdata[3] || !bus_wdata[0])) exp_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else irq <= expire;
  end

  always_comb begin
    case (bus_addr)
      OFF_CTRL: bus_rdata = {{(DATA_W-4){1'b0}}, exp_q, rld_q, run_q, pwr_q};
      OFF_PER:  bus_rdata = per_q;
      OFF_DIV:  bus_rdata = div_q;
      OFF_CNT:  bus_rdata = cnt_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/core_tick_timer_chk.sv
module core_tick_timer_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] per,
  input logic              pwr,
  input logic              run,
  input logic              rld,
  input logic              expd,
  input logic              irq
);
  wire cnt_write = bus_wr && bus_addr == ADDR_W'(12);

  assert_irq_single_R4: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  assert_irq_at_zero_R4: assert property (@(posedge clk) disable iff (rst)
    irq |-> cnt == '0 && expd);
  assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (rst)
    !(pwr && run) && !cnt_write |=> $stable(cnt));
  assert_stay_zero_R4: assert property (@(posedge clk) disable iff (rst)
    cnt == '0 && !rld && !cnt_write |=> cnt == '0);
  assert_period_write_R7: assert property (@(posedge clk) disable iff (rst)
    bus_wr && bus_addr == ADDR_W'(4) |=> per == $past(bus_wdata));
  assert_count_write_wins_R8: assert property (@(posedge clk) disable iff (rst)
    cnt_write |=> cnt == $past(bus_wdata));
endmodule

bind core_tick_timer core_tick_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .cnt(cnt_q), .per(per_q), .pwr(pwr_q), .run(run_q), .rld(rld_q), .expd(exp_q),
  .irq(irq)
);

// File: tb/tb_core_tick_timer.sv
module tb_core_tick_timer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq;
  int            n_chk = 0;
  int            n_err = 0;
  logic [31:0]   held;

  core_tick_timer #(.ADDR_W(AW), .DATA_W(32)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd("R1 ctrl", 5'h0, 0); rd("R1 period", 5'h4, 0);
    rd("R1 div", 5'h8, 0);  rd("R1 count", 5'hC, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // R3/R4 one-shot sweep over divisor and start count
    for (int s = 0; s < 4; s++) begin
      for (int c = 1; c < 6; c++) begin
        wr(5'hC, c); wr(5'h8, s); wr(5'h0, 3);
        for (int k = 1; k <= c*(s+1) + 3; k++) begin
          int e;
          @(negedge clk);
          e = c - k/(s+1);
          if (e < 0) e = 0;
          check("R3 count", bus_rdata & 0, 0);
          bus_addr = 5'hC; #1;
          check("R3 count step", bus_rdata, e);
          check("R4 irq pulse", {31'b0, irq}, (k == c*(s+1)) ? 1 : 0);
        end
        rd("R4 ctrl after expiry", 5'h0, 32'hB);
        wr(5'h0, 0);
        rd("R6 cleared by power off", 5'h0, 0);
      end
    end

    // R5 reload sweep
    for (int s = 0; s < 2; s++) begin
      for (int p = 1; p < 4; p++) begin
        wr(5'hC, 2); wr(5'h4, p); wr(5'h8, s); wr(5'h0, 7);
        for (int k = 1; k <= (s+1)*(3 + 2*(p+1)); k++) begin
          int t, v;
          @(negedge clk);
          t = k/(s+1);
          v = (t <= 2) ? 2 - t : p - ((t-3) % (p+1));
          bus_addr = 5'hC; #1;
          check("R5 reload count", bus_rdata, v);
          check("R5 reload irq", {31'b0, irq},
                ((k % (s+1)) == 0 && t > 0 && v == 0) ? 1 : 0);
        end
        rd("R5 ctrl with reload", 5'h0, 32'hF);
        rd("R7 period while running", 5'h4, p);
        wr(5'h0, 0);
      end
    end

    // R6 sticky flag rules
    wr(5'h8, 0); wr(5'hC, 1); wr(5'h0, 3);
    repeat (3) @(negedge clk);
    rd("R6 set", 5'h0, 32'hB);
    wr(5'h0, 1);
    rd("R6 kept with power on", 5'h0, 32'h9);
    wr(5'h0, 32'hB);
    rd("R6 write one clears", 5'h0, 32'h3);
    wr(5'h0, 0);

    // R8 count write mid-run restarts prescaler
    wr(5'h8, 3); wr(5'hC, 20); wr(5'h0, 3);
    repeat (6) @(negedge clk);
    wr(5'hC, 5);
    rd("R8 count written", 5'hC, 5);
    repeat (3) @(negedge clk);
    rd("R8 no step before phase", 5'hC, 5);
    @(negedge clk);
    rd("R8 step after restart", 5'hC, 4);
    wr(5'h0, 0);

    // R10 start at zero
    wr(5'h8, 0); wr(5'hC, 0); wr(5'h0, 3);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R10 no irq", {31'b0, irq}, 0);
    end
    rd("R10 count zero", 5'hC, 0);
    rd("R10 no flag", 5'h0, 3);
    wr(5'h0, 0);

    // R11/R2 stop and resume
    wr(5'hC, 10); wr(5'h0, 3);
    repeat (3) @(negedge clk);
    wr(5'h0, 0);
    bus_addr = 5'hC; #1; held = bus_rdata;
    check("R11 partial progress", {31'b0, (held < 10 && held > 0)}, 1);
    repeat (5) @(negedge clk);
    rd("R2 held when off", 5'hC, held);
    wr(5'h0, 1);
    repeat (5) @(negedge clk);
    rd("R2 held when powered only", 5'hC, held);
    wr(5'h0, 3);
    for (int k = 1; k <= int'(held); k++) begin
      @(negedge clk);
      check("R11 resume irq", {31'b0, irq}, (k == int'(held)) ? 1 : 0);
    end
    rd("R11 resumed to zero", 5'hC, 0);
    wr(5'h0, 0);

    // R9 unmapped offsets
    wr(5'h4, 32'h60); wr(5'h8, 2); wr(5'hC, 7);
    wr(5'h2, 32'hFFFF_FFFF); wr(5'h5, 32'hFFFF_FFFF); wr(5'h10, 32'hFFFF_FFFF);
    rd("R9 read misaligned", 5'h2, 0);
    rd("R9 read 0x10", 5'h10, 0);
    rd("R9 ctrl untouched", 5'h0, 0);
    rd("R9 period untouched", 5'h4, 32'h60);
    rd("R7 period readback stopped", 5'h4, 32'h60);
    rd("R9 div untouched", 5'h8, 2);
    rd("R9 count untouched", 5'hC, 7);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule